// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-beat read and write requests from an internal requester into machine cycles on a narrow external memory bus. The bus has one 8-bit port that carries first the low address byte and then the data, a separate 8-bit port for the high address byte, an address latch enable, and active-low read and write strobes. Every machine cycle is built from three bus states. Each state lasts a fixed number of clocks, three by default.

A request is accepted only when its address falls in the external window, which covers 0x4000 to 0xFFFF (48 Kbytes) by default. Lower addresses belong to on-chip memory and start no bus activity. During a cycle the block raises a busy flag, and any request offered in that time is dropped, not queued. A read returns its byte with a one-clock done pulse, and so does a write. While reset or the hardware-stop input is active, the strobes and the latch enable are released to high impedance, and this is signalled through a control output-enable. A hardware stop also abandons any cycle in progress.

Top module: `xbus_ctrl`

## Requirements
- R1: During reset `bus_ctl_oe` is 0. After reset the controller is idle: `bus_rd_n`=1, `bus_wr_n`=1, `bus_ale`=0, `bus_ad_oe`=0, `req_busy`=0, `rsp_done`=0 and `bus_ctl_oe`=1.
- R2: A request with address at or above EXT_BASE (0x4000, giving a 48-Kbyte window up to 0xFFFF) starts a bus cycle. A request below EXT_BASE, for example 0x3FFF, causes no ALE, no strobe, no busy and no done.
- R3: The first state (STATE_CLKS clocks, starting in the clock after the accepting edge) drives `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_out` = address bits 7:0 and `bus_hi_addr` = address bits 15:8. `bus_hi_addr` keeps that value for the whole cycle.
- R4: In a read, `bus_rd_n` is 0 for states two and three (2*STATE_CLKS clocks), `bus_ad_oe` is 0 from state two onward, and `bus_wr_n` stays 1.
- R5: In a write, `bus_wr_n` is 0 for states two and three, `bus_ad_oe`=1 with `bus_ad_out` = write data in that time, and `bus_rd_n` stays 1.
- R6: Read data is taken from `bus_ad_in` on the last clock edge of state three, the edge after which `bus_rd_n` returns to 1. `rsp_done` is 1 for exactly the following clock, and `rsp_rdata` holds the captured byte.
- R7: `req_busy` is 1 from the clock after acceptance until the done clock. Requests offered while busy are ignored. A request held through the done clock is accepted at the next edge.
- R8: While `hw_stop`=1, `bus_ctl_oe`=0 and `bus_ad_oe`=0. A cycle in progress is abandoned with no done pulse, and requests are ignored.
- R9: `bus_rd_n` and `bus_wr_n` are never 0 together, and `bus_ale` is never 1 while either strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stop | input | 1 | Hardware stop: float control pins, abandon cycle |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_busy | output | 1 | Bus cycle in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| bus_ad_out | output | 8 | Multiplexed low address / data, driven value |
| bus_ad_oe | output | 1 | Drive enable for the multiplexed port |
| bus_ad_in | input | 8 | Multiplexed port, received value |
| bus_hi_addr | output | 8 | High address byte |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ctl_oe | output | 1 | Drive enable for ALE and both strobes |

## Verification
The assertions check on every cycle that the two strobes never overlap and never coincide with ALE. They also check that a done pulse lasts one clock and always follows the end of state three, that a stop leaves the sequencer idle with no done, and that an on-chip address never raises busy. Only the bench scenarios can show the exact number of clocks in each state, the byte latched from ALE, and the value captured from the bus. The same holds for a request held through busy being dropped or accepted right after done, and for a stop in mid-read producing no completion.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_AW = 16;
    localparam int XB_DW = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic              wr;
        logic [XB_AW-1:0]  addr;
        logic [XB_DW-1:0]  wdata;
        logic [XB_DW-1:0]  rdata;
        logic              done;
    } seq_s;

endpackage

// File: rtl/xbus_state_timer.sv
module xbus_state_timer #(
    parameter int STATE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic state_end
);

    generate
        if (STATE_CLKS <= 1) begin : g_single
            assign state_end = run;
        end else begin : g_count
            localparam int TW = $clog2(STATE_CLKS);
            localparam logic [TW-1:0] LAST = TW'(STATE_CLKS - 1);

            logic [TW-1:0] tick_d, tick_q;

            always_comb begin
                tick_d = tick_q;
                if (!run) begin
                    tick_d = '0;
                end else if (tick_q == LAST) begin
                    tick_d = '0;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tick_q <= '0;
                end else begin
                    tick_q <= tick_d;
                end
            end

            assign state_end = run && (tick_q == LAST);

            // a state spans more than one clock, so two ends never touch (R3)
            assert_state_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
                state_end |=> !state_end);
        end
    endgenerate

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_wr,
    input  logic [XB_AW-1:0] start_addr,
    input  logic [XB_DW-1:0] start_wdata,
    input  logic             state_end,
    input  logic             abort,
    input  logic [XB_DW-1:0] ad_in,
    output phase_e           phase,
    output logic             wr,
    output logic [XB_AW-1:0] addr,
    output logic [XB_DW-1:0] wdata,
    output logic [XB_DW-1:0] rdata,
    output logic             done
);

    seq_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort) begin
            s_d.phase = PH_IDLE;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (start) begin
                        s_d.phase = PH_ADDR;
                        s_d.wr    = start_wr;
                        s_d.addr  = start_addr;
                        s_d.wdata = start_wdata;
                    end
                end
                PH_ADDR: if (state_end) s_d.phase = PH_STRB;
                PH_STRB: if (state_end) s_d.phase = PH_HOLD;
                PH_HOLD: begin
                    if (state_end) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                        if (!s_q.wr) begin
                            s_d.rdata = ad_in;
                        end
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign wr    = s_q.wr;
    assign addr  = s_q.addr;
    assign wdata = s_q.wdata;
    assign rdata = s_q.rdata;
    assign done  = s_q.done;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && state_end && !abort) |=> (done && phase == PH_IDLE));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (phase == PH_IDLE && !done));

    assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(addr));

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
    import xbus_pkg::*;
(
    input  logic             rst_n,
    input  logic             hw_stop,
    input  phase_e           phase,
    input  logic             wr,
    input  logic [XB_AW-1:0] addr,
    input  logic [XB_DW-1:0] wdata,
    output logic             ctl_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             ad_oe,
    output logic [XB_DW-1:0] ad_out,
    output logic [XB_DW-1:0] hi_addr
);

    logic strobe_phase;
    logic addr_phase;

    always_comb begin
        addr_phase   = (phase == PH_ADDR);
        strobe_phase = (phase == PH_STRB) || (phase == PH_HOLD);
        ctl_oe       = rst_n && !hw_stop;
        ale          = addr_phase;
        rd_n         = !(strobe_phase && !wr);
        wr_n         = !(strobe_phase && wr);
        ad_oe        = ctl_oe && (addr_phase || (strobe_phase && wr));
        ad_out       = addr_phase ? addr[XB_DW-1:0] : wdata;
        hi_addr      = addr[XB_AW-1:XB_DW];
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int                STATE_CLKS = 3,
    parameter logic [XB_AW-1:0]  EXT_BASE   = 16'h4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stop,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [XB_DW-1:0] req_wdata,
    output logic             req_busy,
    output logic             rsp_done,
    output logic [XB_DW-1:0] rsp_rdata,
    output logic [XB_DW-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [XB_DW-1:0] bus_ad_in,
    output logic [XB_DW-1:0] bus_hi_addr,
    output logic             bus_ale,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_ctl_oe
);

    phase_e            seq_phase;
    logic              seq_wr;
    logic [XB_AW-1:0]  seq_addr;
    logic [XB_DW-1:0]  seq_wdata;
    logic              state_end;
    logic              ext_hit;
    logic              accept;

    assign ext_hit  = (req_addr >= EXT_BASE);
    assign req_busy = (seq_phase != PH_IDLE);
    assign accept   = req_valid && !req_busy && !hw_stop && ext_hit;

    xbus_state_timer #(
        .STATE_CLKS (STATE_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (req_busy),
        .state_end (state_end)
    );

    xbus_cycle_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_wr    (req_write),
        .start_addr  (req_addr),
        .start_wdata (req_wdata),
        .state_end   (state_end),
        .abort       (hw_stop),
        .ad_in       (bus_ad_in),
        .phase       (seq_phase),
        .wr          (seq_wr),
        .addr        (seq_addr),
        .wdata       (seq_wdata),
        .rdata       (rsp_rdata),
        .done        (rsp_done)
    );

    xbus_pin_drive u_pins (
        .rst_n   (rst_n),
        .hw_stop (hw_stop),
        .phase   (seq_phase),
        .wr      (seq_wr),
        .addr    (seq_addr),
        .wdata   (seq_wdata),
        .ctl_oe  (bus_ctl_oe),
        .ale     (bus_ale),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .ad_oe   (bus_ad_oe),
        .ad_out  (bus_ad_out),
        .hi_addr (bus_hi_addr)
    );

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_ale_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ale && (!bus_rd_n || !bus_wr_n)));

    assert_int_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_busy && req_valid && !ext_hit) |=> !req_busy);

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && !hw_stop) |=> (req_busy || rsp_done));

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n, hw_stop, req_valid, req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, rsp_rdata, bus_ad_out, bus_ad_in, bus_hi_addr;
    logic        req_busy, rsp_done, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_ctl_oe;

    always #10 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_stop(hw_stop),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_busy(req_busy), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_hi_addr(bus_hi_addr), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ctl_oe(bus_ctl_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // external memory model: byte depends on the full latched address
    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    logic [7:0] lat_lo = 8'h00;
    always @(posedge clk) if (bus_ale && bus_ad_oe) lat_lo <= bus_ad_out;
    assign bus_ad_in = (!bus_rd_n) ? mem_f({bus_hi_addr, lat_lo}) : 8'hFF;

    // behavioural reference: position within cycle, -1 when idle
    int          m_pos = -1;
    bit          m_wr = 0, m_done = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_rd = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos <= -1; m_done <= 0; m_rd <= '0;
        end else begin
            m_done <= 0;
            if (hw_stop) begin
                m_pos <= -1;
            end else if (m_pos < 0) begin
                if (req_valid && req_addr >= 16'h4000) begin
                    m_pos <= 0; m_wr <= req_write; m_addr <= req_addr; m_wd <= req_wdata;
                end
            end else if (m_pos == 8) begin
                m_pos <= -1; m_done <= 1;
                if (!m_wr) m_rd <= mem_f(m_addr);
            end else begin
                m_pos <= m_pos + 1;
            end
        end
    end

    int ale_cnt = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;

    always @(negedge clk) begin
        if (chk_en) begin
            logic e_ctl, e_ale, e_rd_n, e_wr_n, e_oe;
            e_ctl  = rst_n && !hw_stop;
            e_ale  = (m_pos >= 0 && m_pos <= 2);
            e_rd_n = !(m_pos >= 3 && !m_wr);
            e_wr_n = !(m_pos >= 3 && m_wr);
            e_oe   = e_ctl && (e_ale || (m_pos >= 3 && m_wr));
            chk("R8", "ctl_oe", bus_ctl_oe, e_ctl);
            chk("R3", "ale", bus_ale, e_ale);
            chk("R4", "rd_n", bus_rd_n, e_rd_n);
            chk("R5", "wr_n", bus_wr_n, e_wr_n);
            chk("R4", "ad_oe", bus_ad_oe, e_oe);
            chk("R7", "busy", req_busy, m_pos >= 0);
            chk("R6", "done", rsp_done, m_done);
            chk("R9", "strobe overlap", !bus_rd_n && !bus_wr_n, 1'b0);
            if (e_oe && e_ale) chk("R3", "ad_out addr", bus_ad_out, m_addr[7:0]);
            if (e_oe && !e_ale) chk("R5", "ad_out data", bus_ad_out, m_wd);
            if (m_pos >= 0) chk("R3", "hi_addr", bus_hi_addr, m_addr[15:8]);
            if (m_pos >= 3) chk("R3", "latched low addr", lat_lo, m_addr[7:0]);
            if (m_done && !m_wr) chk("R6", "rdata", rsp_rdata, m_rd);
            if (bus_ale) ale_cnt++;
            if (!bus_rd_n) rd_cnt++;
            if (!bus_wr_n) wr_cnt++;
            if (rsp_done) done_cnt++;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int a0, r0, w0, d0;
        rst_n = 0; hw_stop = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ctl_oe in reset", bus_ctl_oe, 1'b0);
        @(posedge clk); #2 rst_n = 1;
        @(negedge clk);
        chk("R1", "rd_n idle", bus_rd_n, 1'b1);
        chk("R1", "wr_n idle", bus_wr_n, 1'b1);
        chk("R1", "ale idle", bus_ale, 1'b0);
        chk("R1", "ad_oe idle", bus_ad_oe, 1'b0);
        chk("R1", "busy idle", req_busy, 1'b0);
        chk("R1", "done idle", rsp_done, 1'b0);
        chk("R1", "ctl_oe idle", bus_ctl_oe, 1'b1);
        chk_en = 1;

        // R2: on-chip address just below the window
        a0 = ale_cnt; d0 = done_cnt;
        issue(0, 16'h3FFF, 8'h00); idle(12);
        chk("R2", "ale cycles for 0x3FFF", ale_cnt - a0, 0);
        chk("R2", "done for 0x3FFF", done_cnt - d0, 0);

        // R4/R6: plain read
        a0 = ale_cnt; r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
        issue(0, 16'h4A37, 8'h00); idle(12);
        chk("R3", "ale clocks", ale_cnt - a0, 3);
        chk("R4", "rd low clocks", rd_cnt - r0, 6);
        chk("R4", "wr low clocks in read", wr_cnt - w0, 0);
        chk("R6", "read done", done_cnt - d0, 1);
        chk("R6", "rdata held", rsp_rdata, mem_f(16'h4A37));

        // R5: plain write
        r0 = rd_cnt; w0 = wr_cnt;
        issue(1, 16'hC0FE, 8'h99); idle(12);
        chk("R5", "wr low clocks", wr_cnt - w0, 6);
        chk("R5", "rd low clocks in write", rd_cnt - r0, 0);

        // R7: requests while busy are dropped
        a0 = ale_cnt; w0 = wr_cnt; d0 = done_cnt;
        @(posedge clk); #2;
        req_valid = 1; req_write = 0; req_addr = 16'h5000;
        @(posedge clk); #2;
        req_write = 1; req_addr = 16'h6000; req_wdata = 8'h11;
        repeat (4) @(posedge clk); #2;
        req_valid = 0;
        idle(12);
        chk("R7", "one cycle only", ale_cnt - a0, 3);
        chk("R7", "busy write dropped", wr_cnt - w0, 0);
        chk("R7", "one done", done_cnt - d0, 1);

        // R7: request held through done is taken at once
        a0 = ale_cnt; d0 = done_cnt;
        @(posedge clk); #2;
        req_valid = 1; req_write = 0; req_addr = 16'h8001;
        repeat (15) @(posedge clk); #2;
        req_valid = 0;
        idle(14);
        chk("R7", "back-to-back cycles", ale_cnt - a0, 6);
        chk("R6", "back-to-back done", done_cnt - d0, 2);

        // R8: stop in the middle of a read
        a0 = ale_cnt; d0 = done_cnt;
        issue(0, 16'h7777, 8'h00);
        repeat (3) @(posedge clk); #2;
        hw_stop = 1; req_valid = 1; req_write = 0; req_addr = 16'h9000;
        @(negedge clk);
        chk("R8", "ctl_oe during stop", bus_ctl_oe, 1'b0);
        repeat (3) @(posedge clk); #2;
        hw_stop = 0; req_valid = 0;
        idle(12);
        chk("R8", "no done after stop", done_cnt - d0, 0);
        chk("R8", "no cycle during stop", ale_cnt - a0, 3);

        // R2: window edges
        d0 = done_cnt;
        issue(0, 16'h4000, 8'h00); idle(12);
        issue(1, 16'hFFFF, 8'hA5); idle(12);
        chk("R2", "window edges done", done_cnt - d0, 2);

        chk_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule